// File: doc/BRIEF.md
# Audio Period Transfer Engine

This block is the per-channel engine of a cyclic audio DMA channel. Software, through a descriptor ring upstream of this block, offers descriptors made of a byte length and a notify flag. While the channel's run bit is set and no descriptor is active, the engine takes the next descriptor, loads its length into a residue counter, and then accepts words from the memory side one at a time. Each accepted word is as wide as the configured sample width and lowers the residue by that many bytes. Memory traffic is modelled as strobes: `word_stb` offers one word into the channel buffer, and `drain_stb` hands one word on to the peripheral.

A byte-count limit caps how much the channel buffer may hold. The engine requests more data while the buffer holds less than a threshold. A frame position output shows which word of the current frame goes out next, so the peripheral can tell where each word sits in its frame. When the residue of a descriptor runs out, the engine pushes a report into a four-slot report ring. The report carries the 64-bit running count of bytes accepted since reset and the notify flag. The engine also raises a sticky descriptor-done flag if the descriptor asked for notification. A report that finds the ring full is dropped, and the ring's error flag is set.

Top module: `audio_period_engine`

## Requirements
- R1: `bus_cfg[1:0]` sets the word size: code 0 is 1 byte, code 1 is 2 bytes, codes 2 and 3 are 4 bytes. Each accepted word lowers the residue by that size.
- R2: When no descriptor is active, `run` is 1 and `desc_avail` is 1, `desc_take` is 1 in that cycle. From the next cycle the descriptor is active and `residue` equals `desc_len`, even if the residue was lower before.
- R3: `word_ack` is 1 exactly when `word_stb` is 1, a descriptor is active, `run` is 1, and the buffer occupancy plus the word size does not exceed the limit in `fifo_ctl[31:15+1]` (bits 31 down to 16). An accepted word adds the word size to the occupancy.
- R4: A descriptor completes on an accepted word whose size is at least the remaining residue. The residue then reads 0 and the descriptor becomes inactive. A report is pushed holding the running count of bytes accepted since reset, this word included.
- R5: `rpt_rdata` shows the words of the oldest report in this order: count bits 31:0, count bits 63:32, zero, then a flags word that holds the notify flag in bit 16 and 0 in every other bit. Each `rpt_rd` moves to the next word. After the fourth word the slot is freed. When the ring is empty, `rpt_rdata` is 0.
- R6: `rpt_status` has the write slot in bits [1:0], the read slot in bits [5:4], empty in bit 8, full in bit 9 and the error flag in bit 10. All other bits are 0.
- R7: A report pushed while the ring holds 4 reports is dropped and sets the error flag. `rpt_err_clr` clears the flag, and a new drop in the same cycle takes priority over the clear.
- R8: When a descriptor with its notify flag set completes, `desc_done` becomes 1 in the next cycle. It stays 1 until `done_clr`, and a new completion in the same cycle takes priority over the clear.
- R9: While `run` is 0, no descriptor is taken and no word is accepted. The active descriptor and its residue are kept.
- R10: `fetch_req` is 1 exactly when a descriptor is active, `run` is 1 and the occupancy is below the threshold in `fifo_ctl[15:0]`. A `drain_stb` removes one word's bytes when the occupancy is at least the word size, and otherwise has no effect.
- R11: `frame_pos` advances by one on each drained word and wraps to 0 at the frame size. `bus_cfg[5:4]` sets the frame size: code 0 is 1 word, code 1 is 2 words, codes 2 and 3 are 4 words.
- R12: After reset: no descriptor is active, the residue, the running count, the occupancy and `frame_pos` are 0, `desc_done` is 0, and `rpt_status` reads 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Channel run bit |
| bus_cfg | input | 8 | Word size code in [1:0], frame size code in [5:4] |
| fifo_ctl | input | 32 | Buffer byte limit in [31:16], request threshold in [15:0] |
| desc_avail | input | 1 | The descriptor ring holds a descriptor |
| desc_len | input | LEN_W | Byte length of the offered descriptor |
| desc_notify | input | 1 | Notify flag of the offered descriptor |
| desc_take | output | 1 | Descriptor taken this cycle |
| word_stb | input | 1 | One word offered from memory |
| word_ack | output | 1 | The offered word is accepted |
| drain_stb | input | 1 | The peripheral takes one word |
| residue | output | LEN_W | Bytes remaining in the active descriptor |
| frame_pos | output | 2 | Index within the frame of the next word to drain |
| fetch_req | output | 1 | Request for more words from memory |
| rpt_rd | input | 1 | Pop one report word |
| rpt_err_clr | input | 1 | Clear the report ring error flag |
| rpt_rdata | output | 32 | Current report word |
| rpt_status | output | 11 | Report ring status |
| done_clr | input | 1 | Clear the descriptor-done flag |
| desc_done | output | 1 | Sticky descriptor-done flag |

## Verification
`desc_take`, `word_ack`, `fetch_req` and `rpt_rdata` are combinational. They are due in the cycle the inputs are applied. Residue reloads and decrements, occupancy, `frame_pos`, ring status, the error flag and `desc_done` all take effect one clock edge after the input that causes them. The bench drives inputs just after the falling edge and compares every output against its reference model 1 ns later. The model advances its state once per cycle, in step with the rising edge that follows. Every result is therefore checked in the exact cycle it is due, and never one cycle early or late.

// File: rtl/audio_period_pkg.sv
package audio_period_pkg;
  localparam int RPT_SLOTS = 4;
  localparam int RPT_PTR_W = 2;
  localparam int CNT_W     = 64;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic             notify;
  } report_t;

  // word size in bytes from the width code
  function automatic logic [2:0] word_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // words per frame from the frame code
  function automatic logic [2:0] frame_words(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [10:0] ring_status(input logic [1:0] wr, input logic [1:0] rd,
                                              input logic empty, input logic full,
                                              input logic err);
    return {err, full, empty, 2'b00, rd, 2'b00, wr};
  endfunction
endpackage

// File: rtl/apd_desc_engine.sv
module apd_desc_engine
  import audio_period_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             desc_avail,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_notify,
  input  logic             word_stb,
  input  logic [2:0]       ws,
  input  logic             room_ok,
  output logic             desc_take,
  output logic             word_ack,
  output logic             active,
  output logic [LEN_W-1:0] residue,
  output logic             fin_evt,
  output logic             fin_notify,
  output logic [CNT_W-1:0] fin_count
);
  logic [LEN_W-1:0] ws_ext;
  logic [CNT_W-1:0] run_count;
  logic [CNT_W-1:0] count_next;

  assign ws_ext     = {{(LEN_W-3){1'b0}}, ws};
  assign desc_take  = !active && run && desc_avail;
  assign word_ack   = word_stb && active && run && room_ok;
  assign fin_evt    = word_ack && (residue <= ws_ext);
  assign count_next = run_count + {{(CNT_W-3){1'b0}}, ws};
  assign fin_count  = count_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      residue    <= '0;
      fin_notify <= 1'b0;
      run_count  <= '0;
    end else begin
      if (desc_take) begin
        active     <= 1'b1;
        residue    <= desc_len;
        fin_notify <= desc_notify;
      end else if (word_ack) begin
        run_count <= count_next;
        if (fin_evt) begin
          active  <= 1'b0;
          residue <= '0;
        end else begin
          residue <= residue - ws_ext;
        end
      end
    end
  end
endmodule

// File: rtl/apd_buffer_model.sv
module apd_buffer_model
  import audio_period_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic             drain_stb,
  input  logic             active,
  input  logic             run,
  input  logic [2:0]       ws,
  input  logic [2:0]       fw,
  input  logic [LIM_W-1:0] limit,
  input  logic [LIM_W-1:0] threshold,
  output logic             room_ok,
  output logic             fetch_req,
  output logic [LIM_W+1:0] occ,
  output logic [1:0]       frame_pos
);
  localparam int OCC_W = LIM_W + 2;

  logic [OCC_W-1:0] ws_ext;
  logic             drain;
  logic [2:0]       pos_inc;

  assign ws_ext    = {{(OCC_W-3){1'b0}}, ws};
  assign room_ok   = (occ + ws_ext) <= {2'b00, limit};
  assign fetch_req = active && run && (occ < {2'b00, threshold});
  assign drain     = drain_stb && (occ >= ws_ext);
  assign pos_inc   = {1'b0, frame_pos} + 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ       <= '0;
      frame_pos <= '0;
    end else begin
      occ <= occ + (fill ? ws_ext : '0) - (drain ? ws_ext : '0);
      if (drain) frame_pos <= (pos_inc >= fw) ? 2'd0 : pos_inc[1:0];
    end
  end
endmodule

// File: rtl/apd_report_ring.sv
module apd_report_ring
  import audio_period_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] push_count,
  input  logic             push_notify,
  input  logic             rd,
  input  logic             err_clr,
  output logic [31:0]      rdata,
  output logic [10:0]      status,
  output logic             full,
  output logic             err
);
  report_t             slots [RPT_SLOTS];
  logic [RPT_PTR_W-1:0] wr_ptr, rd_ptr;
  logic [RPT_PTR_W:0]   fill_cnt;
  logic [1:0]           widx;
  logic                 empty, push_ok, pop_word, pop_done;
  report_t              head;

  assign empty    = (fill_cnt == '0);
  assign full     = (fill_cnt == (RPT_PTR_W+1)'(RPT_SLOTS));
  assign push_ok  = push && !full;
  assign pop_word = rd && !empty;
  assign pop_done = pop_word && (widx == 2'd3);
  assign head     = slots[rd_ptr];
  assign status   = ring_status(wr_ptr, rd_ptr, empty, full, err);

  always_comb begin
    rdata = '0;
    if (!empty) begin
      case (widx)
        2'd0: rdata = head.count[31:0];
        2'd1: rdata = head.count[63:32];
        2'd2: rdata = '0;
        default: rdata = {15'd0, head.notify, 16'd0};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
      widx     <= '0;
      err      <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_word) widx <= widx + 2'd1;
      if (pop_done) rd_ptr <= rd_ptr + 1'b1;
      fill_cnt <= fill_cnt + (push_ok ? 1'b1 : 1'b0) - (pop_done ? 1'b1 : 1'b0);
      if (push && full) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  for (genvar g = 0; g < RPT_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots[g] <= '0;
      else if (push_ok && (wr_ptr == RPT_PTR_W'(g))) slots[g] <= '{count: push_count, notify: push_notify};
    end
  end
endmodule

// File: rtl/audio_period_engine.sv
module audio_period_engine
  import audio_period_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [7:0]       bus_cfg,
  input  logic [31:0]      fifo_ctl,
  input  logic             desc_avail,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_notify,
  output logic             desc_take,
  input  logic             word_stb,
  output logic             word_ack,
  input  logic             drain_stb,
  output logic [LEN_W-1:0] residue,
  output logic [1:0]       frame_pos,
  output logic             fetch_req,
  input  logic             rpt_rd,
  input  logic             rpt_err_clr,
  output logic [31:0]      rpt_rdata,
  output logic [10:0]      rpt_status,
  input  logic             done_clr,
  output logic             desc_done
);
  logic [2:0]       ws, fw;
  logic             room_ok, active, fin_evt, fin_notify, ring_full, rpt_err;
  logic [CNT_W-1:0] fin_count;
  logic [LIM_W+1:0] occ;
  logic [LIM_W-1:0] limit, threshold;

  assign ws        = word_bytes(bus_cfg[1:0]);
  assign fw        = frame_words(bus_cfg[5:4]);
  assign limit     = fifo_ctl[16 +: LIM_W];
  assign threshold = fifo_ctl[LIM_W-1:0];

  apd_desc_engine #(.LEN_W(LEN_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .run(run), .desc_avail(desc_avail), .desc_len(desc_len),
    .desc_notify(desc_notify), .word_stb(word_stb), .ws(ws), .room_ok(room_ok),
    .desc_take(desc_take), .word_ack(word_ack), .active(active), .residue(residue),
    .fin_evt(fin_evt), .fin_notify(fin_notify), .fin_count(fin_count)
  );

  apd_buffer_model #(.LIM_W(LIM_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .fill(word_ack), .drain_stb(drain_stb), .active(active),
    .run(run), .ws(ws), .fw(fw), .limit(limit), .threshold(threshold), .room_ok(room_ok),
    .fetch_req(fetch_req), .occ(occ), .frame_pos(frame_pos)
  );

  apd_report_ring ring_i (
    .clk(clk), .rst_n(rst_n), .push(fin_evt), .push_count(fin_count), .push_notify(fin_notify),
    .rd(rpt_rd), .err_clr(rpt_err_clr), .rdata(rpt_rdata), .status(rpt_status),
    .full(ring_full), .err(rpt_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) desc_done <= 1'b0;
    else if (fin_evt && fin_notify) desc_done <= 1'b1;
    else if (done_clr) desc_done <= 1'b0;
  end
endmodule

// File: rtl/audio_period_engine_chk.sv
module audio_period_engine_chk #(
  parameter int LEN_W = 16,
  parameter int LIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             desc_take,
  input logic             active,
  input logic [LEN_W-1:0] residue,
  input logic             fin_evt,
  input logic             fin_notify,
  input logic             ring_full,
  input logic             rpt_err,
  input logic             desc_done,
  input logic             word_ack,
  input logic [LIM_W+1:0] occ,
  input logic [LIM_W-1:0] limit
);
  p_residue_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_take |=> residue <= $past(residue));
  p_load_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_take |=> active);
  p_stop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(residue) && $stable(active)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_ack |=> occ <= {2'b00, $past(limit)});
  p_drop_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && ring_full) |=> rpt_err);
  p_notify_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && fin_notify) |=> desc_done);
endmodule

bind audio_period_engine audio_period_engine_chk #(.LEN_W(LEN_W), .LIM_W(LIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .desc_take(desc_take), .active(active),
  .residue(residue), .fin_evt(fin_evt), .fin_notify(fin_notify), .ring_full(ring_full),
  .rpt_err(rpt_err), .desc_done(desc_done), .word_ack(word_ack), .occ(occ), .limit(limit)
);

// File: tb/audio_period_engine_tb_top.sv
`timescale 1ns/1ps
module audio_period_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        run = 0, desc_avail = 0, desc_notify = 0, word_stb = 0, drain_stb = 0;
  logic        rpt_rd = 0, rpt_err_clr = 0, done_clr = 0;
  logic [7:0]  bus_cfg = 0;
  logic [31:0] fifo_ctl = 0;
  logic [15:0] desc_len = 0;
  logic        desc_take, word_ack, fetch_req, desc_done;
  logic [15:0] residue;
  logic [1:0]  frame_pos;
  logic [31:0] rpt_rdata;
  logic [10:0] rpt_status;

  audio_period_engine dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .bus_cfg(bus_cfg), .fifo_ctl(fifo_ctl),
    .desc_avail(desc_avail), .desc_len(desc_len), .desc_notify(desc_notify),
    .desc_take(desc_take), .word_stb(word_stb), .word_ack(word_ack), .drain_stb(drain_stb),
    .residue(residue), .frame_pos(frame_pos), .fetch_req(fetch_req), .rpt_rd(rpt_rd),
    .rpt_err_clr(rpt_err_clr), .rpt_rdata(rpt_rdata), .rpt_status(rpt_status),
    .done_clr(done_clr), .desc_done(desc_done)
  );

  int vectors = 0, errors = 0, cycles = 0;
  logic [31:0] rng = 32'h1234_5678;

  // reference model state
  bit              m_act, m_notify, m_done, m_err;
  int              m_res, m_occ, m_fpos, m_wr, m_rd, m_widx;
  longint unsigned m_cnt;
  longint unsigned q_cnt[$];
  bit              q_ntf[$];

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // one cycle: inputs are already applied; compare, then advance the model
  task automatic step();
    int ws, fw, lim, thr, sz;
    bit take, fill, fin, drain, fetch, popw;
    longint unsigned rdat, stat;
    ws  = (bus_cfg[1:0] == 0) ? 1 : (bus_cfg[1:0] == 1) ? 2 : 4;
    fw  = (bus_cfg[5:4] == 0) ? 1 : (bus_cfg[5:4] == 1) ? 2 : 4;
    lim = fifo_ctl[31:16];
    thr = fifo_ctl[15:0];
    take  = !m_act && run && desc_avail;
    fill  = word_stb && m_act && run && (m_occ + ws <= lim);
    fin   = fill && (m_res <= ws);
    fetch = m_act && run && (m_occ < thr);
    drain = drain_stb && (m_occ >= ws);
    sz = q_cnt.size();
    rdat = 0;
    if (sz != 0) begin
      case (m_widx)
        0: rdat = q_cnt[0] & 64'hFFFF_FFFF;
        1: rdat = q_cnt[0] >> 32;
        2: rdat = 0;
        default: rdat = q_ntf[0] ? 64'h1_0000 : 0;
      endcase
    end
    stat = (longint'(m_err) << 10) | (longint'(sz == 4) << 9) | (longint'(sz == 0) << 8) |
           ((m_rd % 4) << 4) | (m_wr % 4);
    vectors++;
    chk("R2 desc_take", desc_take, take);
    chk("R3 word_ack", word_ack, fill);
    chk("R10 fetch_req", fetch_req, fetch);
    chk("R1/R4 residue", residue, m_res);
    chk("R11 frame_pos", frame_pos, m_fpos);
    chk("R5 rpt_rdata", rpt_rdata, rdat);
    chk("R6/R7 rpt_status", rpt_status, stat);
    chk("R8 desc_done", desc_done, m_done);
    // advance
    popw = rpt_rd && sz != 0;
    if (fill) m_cnt += ws;
    if (popw) begin
      if (m_widx == 3) begin
        void'(q_cnt.pop_front()); void'(q_ntf.pop_front());
        m_rd++; m_widx = 0;
      end else m_widx++;
    end
    if (fin) begin
      if (sz < 4) begin q_cnt.push_back(m_cnt); q_ntf.push_back(m_notify); m_wr++; end
    end
    if (fin && sz == 4) m_err = 1; else if (rpt_err_clr) m_err = 0;
    if (fin && m_notify) m_done = 1; else if (done_clr) m_done = 0;
    if (take) begin m_act = 1; m_res = desc_len; m_notify = desc_notify; end
    else if (fill) begin
      if (fin) begin m_act = 0; m_res = 0; end else m_res -= ws;
    end
    m_occ = m_occ + (fill ? ws : 0) - (drain ? ws : 0);
    if (drain) m_fpos = (m_fpos + 1 >= fw) ? 0 : m_fpos + 1;
  endtask

  task automatic phase(input int n, input logic [7:0] cfg, input logic [31:0] fctl,
                       input bit reads_on, input bit err_clr_on);
    bus_cfg = cfg; fifo_ctl = fctl;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rng = nxt(rng);
      run         = (rng[3:0] != 0);
      desc_avail  = rng[4];
      desc_len    = 16'(1 + (rng[10:5] % 40));
      desc_notify = rng[11];
      word_stb    = (rng[13:12] != 0);
      drain_stb   = rng[14];
      rpt_rd      = reads_on && rng[15];
      done_clr    = (rng[20:16] == 0);
      rpt_err_clr = err_clr_on && (rng[23:21] == 0);
      #1 step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state observed while reset is still applied
    vectors++;
    chk("R12 residue", residue, 0);
    chk("R12 rpt_status", rpt_status, 11'h100);
    chk("R12 desc_done", desc_done, 0);
    chk("R12 frame_pos", frame_pos, 0);
    rst_n = 1'b1;
    // R9: idle with run low, nothing may be taken
    repeat (5) begin @(negedge clk); run = 0; desc_avail = 1; desc_len = 16'd8; #1 step(); end
    phase(800, 8'h00, {16'd16, 16'd8}, 1, 1);  // R1 8-bit, 1-word frames
    phase(800, 8'h11, {16'd12, 16'd6}, 1, 1);  // R1/R11 16-bit, 2-word frames
    phase(800, 8'h22, {16'd12, 16'd6}, 1, 1);  // R1/R11 32-bit, 4-word frames
    phase(800, 8'h33, {16'd20, 16'd4}, 1, 1);  // R1/R11 code 3 variants
    phase(600, 8'h01, {16'd4, 16'd2}, 0, 0);   // R7 ring overflow, no reads
    phase(400, 8'h02, {16'd8, 16'd8}, 1, 1);   // R5/R7 drain ring and clear error
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end
endmodule